// File: doc/BRIEF.md
# Sliding-Window MAP Schedule Controller

This block sequences a radix-2, eight-state soft-in soft-out decoder that uses the max-log-MAP algorithm with sliding windows. A frame of N trellis stages is cut into windows of M stages, and the last window is shortened when N is not a multiple of M. Time is divided into window periods of M clock cycles, with one stage per cycle. The controller runs a fixed staggered pipeline over these periods. In period p, branch metrics for window p are generated and stored. The forward recursion runs for window p-2, and the dummy backward recursion that prepares window p-2 runs at the same time. The real backward recursion with LLR output runs for window p-3.

The controller drives only enables, bank selects, slot addresses and seed strobes. The arithmetic units consume these. Three branch-metric banks rotate between windows. A single forward-metric memory of M slots is written and read in the same period. The slot order flips on every window, so a read always takes a slot in the same cycle that the slot is rewritten. The memory is read-before-write. A one-cycle start pulse launches a frame. A done flag rises after the last LLR strobe and stays high until the next frame is accepted.

Top module: `swmap_sched`

## Requirements
- R1: After reset, and whenever no frame is running, busy, done and all four phase enables (bmg_en, fwd_en, dum_en, llr_valid) are 0.
- R2: A start pulse with nonzero frame_len while idle makes busy 1 from the next cycle, which is period 1 at cycle 0. A start while busy, or with frame_len 0, changes nothing.
- R3: In period p, bmg_en marks branch-metric generation for window p, one stage per cycle in ascending order. Bank selects use code (w-1) mod 3 for window w, taking values 0, 1, 2. This applies to bmg_bank, fwd_bank, dum_bank and bwd_bank.
- R4: In period p, fwd_en marks the forward recursion of window p-2 in ascending stage order. fwd_init is 1 only on the first cycle of window 1, at stage 0, where the forward metrics start as 0 for state 0 and as the most negative value for the other states.
- R5: In period p with p>=3, dum_en marks the dummy backward pass for window p-2. The pass walks window p-1's stages in descending order. dum_seed is 1 on its first cycle. dum_seed_est is 1 when window p exists, meaning the seed is estimated from window p's stage-0 branch metrics produced in that same cycle. It is 0 when the seed uses equal metrics.
- R6: In period p, llr_valid marks the backward and LLR pass for window p-3, walking stages from the window's last stage down to 0. llr_idx equals (w-1)*M + stage. bwd_seed is 1 on the first cycle. bwd_seed_dum is 1 when window w has a successor window, so the seed is the dummy result; otherwise it is 0 and the seed uses equal metrics.
- R7: Every bank and forward-memory address is a slot. Odd windows (1, 3, ...) keep stage s in slot s, and even windows keep it in slot M-1-s. When fwd_en and llr_valid are both 1, fwd_addr equals bwd_addr. When bmg_en and llr_valid are both 1, bmg_addr equals bwd_addr.
- R8: The last window covers N-(W-1)*M stages, where W = ceil(N/M). Each phase is active only for the stages of windows 1..W and stays quiet otherwise.
- R9: One cycle after the last LLR strobe of a frame (the final period is cut short to the last window's length), busy drops and done rises. done then holds until another frame is accepted.
- R10: During a frame, every index 0..N-1 appears on llr_idx with llr_valid exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame launch pulse |
| frame_len | input | LEN_W | Number of trellis stages N, sampled on start |
| busy | output | 1 | Frame in progress |
| done | output | 1 | All LLRs of the last frame issued |
| bmg_en | output | 1 | Branch-metric generation active |
| bmg_bank | output | 2 | Bank written by generation |
| bmg_addr | output | $clog2(M) | Slot written by generation |
| fwd_en | output | 1 | Forward recursion active; also the forward-memory write enable |
| fwd_init | output | 1 | Load initial forward metrics |
| fwd_bank | output | 2 | Bank read by forward recursion |
| fwd_addr | output | $clog2(M) | Bank slot read, and forward-memory slot written |
| dum_en | output | 1 | Dummy backward recursion active |
| dum_seed | output | 1 | First dummy cycle: load seed |
| dum_seed_est | output | 1 | Seed from estimate (1) or equal metrics (0) |
| dum_bank | output | 2 | Bank read by dummy recursion |
| dum_addr | output | $clog2(M) | Slot read by dummy recursion |
| llr_valid | output | 1 | Backward recursion and LLR output active |
| bwd_seed | output | 1 | First backward cycle: load seed |
| bwd_seed_dum | output | 1 | Seed from dummy result (1) or equal metrics (0) |
| bwd_bank | output | 2 | Bank read by backward pass |
| bwd_addr | output | $clog2(M) | Bank slot and forward-memory slot read |
| llr_idx | output | LEN_W | Absolute stage index of the LLR being produced |

## Verification
A behavioural model predicts every output on every cycle. The bench runs frames of several lengths:
- a single one-stage window, where most phases are suppressed;
- an exact multiple of M;
- a last window of one stage;
- last windows of a few stages with both odd and even window counts.

Together these separate the bank rotation, the flipping of slot direction and the end-of-frame suppression. A start pulse during a frame and one with length zero show that neither disturbs the schedule. A coverage tally confirms that each LLR index is issued exactly once.

// File: rtl/swmap_pkg.sv
package swmap_pkg;

    typedef logic [1:0] bank_t;

    localparam int NUM_BANKS  = 3;
    localparam int NUM_PHASES = 4;

    // bank of the window that is k periods older than the current one
    function automatic bank_t bank_back(bank_t cur, int unsigned k);
        int unsigned v;
        v = {30'd0, cur} + 32'(NUM_BANKS * NUM_PHASES) - k;
        return bank_t'(v % NUM_BANKS);
    endfunction

endpackage

// File: rtl/swmap_tick.sv
module swmap_tick #(
    parameter int M     = 32,
    parameter int LEN_W = 13,
    localparam int SW   = $clog2(M),
    localparam int PW   = LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    output logic             busy,
    output logic             done,
    output logic [PW-1:0]    per,
    output logic [SW-1:0]    cyc,
    output logic [PW-1:0]    nwin,
    output logic [SW:0]      lastlen,
    output logic             go,
    output logic             adv
);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [PW-1:0] per;
        logic [SW-1:0] cyc;
        logic [PW-1:0] nwin;
        logic [SW:0]   lastlen;
    } tick_t;

    tick_t st_d, st_q;
    logic [PW-1:0] nwin_calc;
    logic [SW:0]   last_calc;
    logic          final_cyc;

    always_comb begin
        nwin_calc = PW'((32'(frame_len) + 32'(M) - 32'd1) / 32'(M));
        last_calc = (SW+1)'(32'(frame_len) - (32'(nwin_calc) - 32'd1) * 32'(M));
        go        = start && !st_q.busy && (frame_len != '0);
        final_cyc = st_q.busy && (st_q.per == st_q.nwin + PW'(3))
                    && ({1'b0, st_q.cyc} == st_q.lastlen - (SW+1)'(1));
        adv       = st_q.busy && !final_cyc && (st_q.cyc == SW'(M - 1));

        st_d = st_q;
        if (go) begin
            st_d.busy    = 1'b1;
            st_d.done    = 1'b0;
            st_d.per     = PW'(1);
            st_d.cyc     = '0;
            st_d.nwin    = nwin_calc;
            st_d.lastlen = last_calc;
        end else if (final_cyc) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.cyc  = '0;
        end else if (adv) begin
            st_d.cyc = '0;
            st_d.per = st_q.per + PW'(1);
        end else if (st_q.busy) begin
            st_d.cyc = st_q.cyc + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign per     = st_q.per;
    assign cyc     = st_q.cyc;
    assign nwin    = st_q.nwin;
    assign lastlen = st_q.lastlen;

    // R2: an accepted start always lands on period 1, cycle 0
    assert_start_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (busy && per == PW'(1) && cyc == '0));

    // R9: the frame always closes in its final period
    assert_close_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && per == nwin + PW'(3)));

endmodule

// File: rtl/swmap_bank_rot.sv
module swmap_bank_rot
    import swmap_pkg::*;
#(
    parameter int TAPS = NUM_PHASES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 adv,
    output logic [TAPS-1:0][1:0] taps
);

    bank_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (clr)      cur_d = '0;
        else if (adv) cur_d = (cur_q == bank_t'(NUM_BANKS - 1)) ? '0 : cur_q + bank_t'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign taps[k] = bank_back(cur_q, k);
    end

    // R3: each period boundary moves the write bank on by one, modulo three
    assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (cur_q != $past(cur_q) && cur_q != bank_t'(NUM_BANKS)));

endmodule

// File: rtl/swmap_slot.sv
module swmap_slot #(
    parameter int M   = 32,
    localparam int SW = $clog2(M)
) (
    input  logic [SW-1:0] stage,
    input  logic          odd_win,
    output logic [SW-1:0] slot
);

    always_comb begin
        if (odd_win) slot = stage;
        else         slot = SW'(M - 1) - stage;
    end

endmodule

// File: rtl/swmap_sched.sv
module swmap_sched
    import swmap_pkg::*;
#(
    parameter int M     = 32,
    parameter int LEN_W = 13,
    localparam int SW   = $clog2(M)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    output logic             busy,
    output logic             done,
    output logic             bmg_en,
    output logic [1:0]       bmg_bank,
    output logic [SW-1:0]    bmg_addr,
    output logic             fwd_en,
    output logic             fwd_init,
    output logic [1:0]       fwd_bank,
    output logic [SW-1:0]    fwd_addr,
    output logic             dum_en,
    output logic             dum_seed,
    output logic             dum_seed_est,
    output logic [1:0]       dum_bank,
    output logic [SW-1:0]    dum_addr,
    output logic             llr_valid,
    output logic             bwd_seed,
    output logic             bwd_seed_dum,
    output logic [1:0]       bwd_bank,
    output logic [SW-1:0]    bwd_addr,
    output logic [LEN_W-1:0] llr_idx
);

    localparam int PW = LEN_W + 1;

    logic [PW-1:0]   per, nwin;
    logic [SW-1:0]   cyc;
    logic [SW:0]     lastlen;
    logic            go, adv;
    logic [NUM_PHASES-1:0][1:0]    taps;
    logic [NUM_PHASES-1:0]         act;
    logic [NUM_PHASES-1:0][SW-1:0] slot;
    logic [SW-1:0]   bwd_stage;

    swmap_tick #(.M(M), .LEN_W(LEN_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .busy(busy), .done(done), .per(per), .cyc(cyc), .nwin(nwin),
        .lastlen(lastlen), .go(go), .adv(adv)
    );

    swmap_bank_rot #(.TAPS(NUM_PHASES)) u_rot (
        .clk(clk), .rst_n(rst_n), .clr(go), .adv(adv), .taps(taps)
    );

    // phase k serves window per-k; odd k walks its window downwards
    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_ph
        logic [PW-1:0] win;
        logic [SW:0]   wl;
        logic          a;
        logic [SW-1:0] stg;

        always_comb begin
            win = per - PW'(k);
            wl  = (win == nwin) ? lastlen : (SW+1)'(M);
            a   = busy && (win != '0) && (win <= nwin) && ({1'b0, cyc} < wl);
            if (k % 2 == 1) stg = SW'(wl - (SW+1)'(1) - {1'b0, cyc});
            else            stg = cyc;
        end

        swmap_slot #(.M(M)) u_slot (.stage(stg), .odd_win(win[0]), .slot(slot[k]));
        assign act[k] = a;

        if (k == NUM_PHASES - 1) begin : g_idx
            assign bwd_stage = stg;
        end
    end

    always_comb begin
        bmg_en       = act[0];
        bmg_bank     = taps[0];
        bmg_addr     = slot[0];

        fwd_en       = act[2];
        fwd_bank     = taps[2];
        fwd_addr     = slot[2];
        fwd_init     = act[2] && (per == PW'(3)) && (cyc == '0);

        dum_en       = act[1] && (per >= PW'(3));
        dum_bank     = taps[1];
        dum_addr     = slot[1];
        dum_seed     = dum_en && (cyc == '0);
        dum_seed_est = (per <= nwin);

        llr_valid    = act[3];
        bwd_bank     = taps[3];
        bwd_addr     = slot[3];
        bwd_seed     = act[3] && (cyc == '0);
        bwd_seed_dum = (per <= nwin + PW'(2));
        llr_idx      = LEN_W'(per - PW'(4)) * LEN_W'(M) + LEN_W'(bwd_stage);
    end

    // R7: the forward memory slot read is the slot rewritten in that cycle
    assert_fm_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_en && llr_valid) |-> (fwd_addr == bwd_addr));

    // R7: a shared branch-metric bank is read and rewritten at the same slot
    assert_bm_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bmg_en && llr_valid) |-> (bmg_addr == bwd_addr && bmg_bank == bwd_bank));

    // R3: generation never writes the bank the forward pass is reading
    assert_bank_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bmg_en && fwd_en) |-> (bmg_bank != fwd_bank && bmg_bank != dum_bank));

    // R1: nothing is enabled outside a frame
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bmg_en || fwd_en || dum_en || llr_valid));

    // R4: forward initialisation happens at stage 0 of window 1 in bank 0
    assert_fwd_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_init |-> (fwd_en && fwd_addr == '0 && fwd_bank == 2'd0));

    // R6: within a window the LLR index counts down by one each cycle
    assert_llr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (llr_valid && $past(llr_valid) && !bwd_seed) |-> (llr_idx == $past(llr_idx) - LEN_W'(1)));

    // R9: done and busy never overlap
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/swmap_sched_test.sv
`timescale 1ns/1ps
module swmap_sched_test;

    localparam int M     = 32;
    localparam int LEN_W = 13;
    localparam int SW    = $clog2(M);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic busy, done, bmg_en, fwd_en, fwd_init, dum_en, dum_seed, dum_seed_est;
    logic llr_valid, bwd_seed, bwd_seed_dum;
    logic [1:0] bmg_bank, fwd_bank, dum_bank, bwd_bank;
    logic [SW-1:0] bmg_addr, fwd_addr, dum_addr, bwd_addr;
    logic [LEN_W-1:0] llr_idx;

    int checks = 0;
    int fails  = 0;
    int nw, lw;
    int hits [512];

    always #2.5 clk = ~clk;

    swmap_sched #(.M(M), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
        .busy(busy), .done(done),
        .bmg_en(bmg_en), .bmg_bank(bmg_bank), .bmg_addr(bmg_addr),
        .fwd_en(fwd_en), .fwd_init(fwd_init), .fwd_bank(fwd_bank), .fwd_addr(fwd_addr),
        .dum_en(dum_en), .dum_seed(dum_seed), .dum_seed_est(dum_seed_est),
        .dum_bank(dum_bank), .dum_addr(dum_addr),
        .llr_valid(llr_valid), .bwd_seed(bwd_seed), .bwd_seed_dum(bwd_seed_dum),
        .bwd_bank(bwd_bank), .bwd_addr(bwd_addr), .llr_idx(llr_idx)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wlen(int w);
        return (w == nw) ? lw : M;
    endfunction

    function automatic int slotf(int w, int s);
        return (w % 2 == 1) ? s : M - 1 - s;
    endfunction

    function automatic bit inwin(int w, int c);
        return (w >= 1) && (w <= nw) && (c < wlen(w));
    endfunction

    task automatic idle_check(input string req, input bit exp_done);
        chk(req, "busy", busy, 0);
        chk(req, "done", done, exp_done);
        chk("R1", "any enable while idle", {bmg_en, fwd_en, dum_en, llr_valid}, 0);
    endtask

    task automatic cycle_check(input int p, input int c);
        int w, s;
        bit e;
        chk("R2", "busy", busy, 1);
        chk("R9", "done during frame", done, 0);
        // R3 generation for window p
        e = inwin(p, c);
        chk("R8", "bmg_en", bmg_en, e);
        if (e) begin
            chk("R3", "bmg_bank", bmg_bank, (p - 1) % 3);
            chk("R7", "bmg_addr", bmg_addr, slotf(p, c));
        end
        // R4 forward for window p-2
        w = p - 2;
        e = inwin(w, c);
        chk("R8", "fwd_en", fwd_en, e);
        chk("R4", "fwd_init", fwd_init, e && w == 1 && c == 0);
        if (e) begin
            chk("R3", "fwd_bank", fwd_bank, (w - 1) % 3);
            chk("R7", "fwd_addr", fwd_addr, slotf(w, c));
        end
        // R5 dummy pass over window p-1
        w = p - 1;
        e = (p >= 3) && inwin(w, c);
        chk("R5", "dum_en", dum_en, e);
        if (e) begin
            s = wlen(w) - 1 - c;
            chk("R5", "dum_seed", dum_seed, c == 0);
            chk("R5", "dum_seed_est", dum_seed_est, p <= nw);
            chk("R3", "dum_bank", dum_bank, (w - 1) % 3);
            chk("R7", "dum_addr", dum_addr, slotf(w, s));
        end
        // R6 backward and LLR for window p-3
        w = p - 3;
        e = inwin(w, c);
        chk("R8", "llr_valid", llr_valid, e);
        if (e) begin
            s = wlen(w) - 1 - c;
            chk("R6", "bwd_seed", bwd_seed, c == 0);
            chk("R6", "bwd_seed_dum", bwd_seed_dum, w < nw);
            chk("R3", "bwd_bank", bwd_bank, (w - 1) % 3);
            chk("R7", "bwd_addr", bwd_addr, slotf(w, s));
            chk("R6", "llr_idx", llr_idx, (w - 1) * M + s);
        end
        if (llr_valid && int'(llr_idx) < 512) hits[int'(llr_idx)]++;
    endtask

    task automatic run_frame(input int n, input int poke);
        int cnt = 0;
        int bad = 0;
        nw = (n + M - 1) / M;
        lw = n - (nw - 1) * M;
        foreach (hits[i]) hits[i] = 0;
        @(negedge clk);
        start = 1'b1;
        frame_len = LEN_W'(n);
        @(negedge clk);
        start = 1'b0;
        for (int p = 1; p <= nw + 3; p++) begin
            for (int c = 0; c < ((p == nw + 3) ? lw : M); c++) begin
                cycle_check(p, c);
                if (cnt == poke) begin
                    // R2: start while busy must be ignored
                    start = 1'b1;
                    frame_len = LEN_W'(5);
                end
                cnt++;
                @(negedge clk);
                start = 1'b0;
            end
        end
        idle_check("R9", 1'b1);
        for (int i = 0; i < n; i++) if (hits[i] != 1) bad++;
        chk("R10", "LLR indices not issued exactly once", bad, 0);
        @(negedge clk);
        chk("R9", "done held", done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1", 1'b0);
        run_frame(70, -1);
        run_frame(1, -1);
        run_frame(32, -1);
        run_frame(100, 40);
        run_frame(33, -1);
        // R2: zero-length start is ignored
        start = 1'b1;
        frame_len = '0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        idle_check("R2", 1'b1);
        run_frame(96, 10);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule